// File: doc/BRIEF.md
# Masked Local Interrupt Controller

This block merges sixteen level-sensitive interrupt request lines into one interrupt output for the processor. Each request line is sampled into a source register on every clock. The source register follows the line level and never holds a request once the line drops. A software-owned enable mask selects which sources may drive the output. The output is high whenever at least one source is both active and enabled.

Software reaches the block through a small 16-bit register port addressed by byte offset. The vector register is read-only. It reports the lowest-numbered source that is both active and enabled, encoded so that zero means nothing is pending. The enable mask register can be read and written. The lowest index always wins: there is no programmable priority, no edge capture and no nesting.

Top module: `maskirq_ctrl`

## Requirements
- R1: Each bit of the source register equals the level its request line had at the previous rising clock edge. Nothing is latched: a line that goes low clears its bit one cycle later.
- R2: `irq_o` is high in the cycle after an edge exactly when the source register and the enable mask, as updated by that edge, share at least one set bit. Otherwise it is low.
- R3: A read at byte offset 0x000 returns ((n+1) << 2), where n is the lowest bit index set in (source AND mask), for example 0x0004 for source 0 and 0x0040 for source 15. It returns 0x0000 when no bit is set.
- R4: A write at byte offset 0x002 loads the enable mask from `acc_wdata_i` (bit i enables source i) at that clock edge. A read at offset 0x002 returns the mask.
- R5: While reset is held and after it is released, the mask is 0x0010 (only source 4 enabled), the source register is 0, and both `irq_o` and `acc_rdata_o` are 0.
- R6: A read at any offset other than 0x000 and 0x002, odd offsets included, returns 0x0000.
- R7: A write at any offset other than 0x002, the vector offset 0x000 included, leaves the mask and `irq_o` unchanged.
- R8: Reading the vector register changes neither the source register nor the mask: repeated reads under steady inputs return the same code.
- R9: Read data appears on `acc_rdata_o` in the cycle after `acc_rd_i` and reflects the state before that edge. `acc_rdata_o` is 0x0000 in a cycle that follows no read. A read and a write of the mask in the same cycle return the old mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| irq_req_i | input | 16 | Level-sensitive request lines, synchronous to `clk` |
| acc_addr_i | input | 12 | Byte offset of the register access |
| acc_rd_i | input | 1 | Read strobe |
| acc_wr_i | input | 1 | Write strobe |
| acc_wdata_i | input | 16 | Write data |
| acc_rdata_o | output | 16 | Read data, valid the cycle after a read strobe |
| irq_o | output | 1 | Combined interrupt output, registered |

## Verification
Two pairs of functions can land in the same cycle. A mask write can coincide with a change on the request lines, and a read of the mask can coincide with a write of it. The bench drives both pairs in one cycle, in directed steps and in a long random stretch where strobes, offsets and line levels change together. A behavioural reference model updates its source, mask and read data from the same stimulus on every edge. On each falling edge its expected `irq_o` and `acc_rdata_o` are compared with the design, so the combined output must reflect the new lines and the new mask together, and a colliding read must return the mask as it stood before the write.

// File: rtl/maskirq_pkg.sv
package maskirq_pkg;

  // Register selected by a decoded access.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_VEC  = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;

  // Byte offsets of the two registers on the 16-bit access port.
  localparam int unsigned OFF_VECTOR = 0;
  localparam int unsigned OFF_MASK   = 2;

endpackage

// File: rtl/maskirq_src_sample.sv
module maskirq_src_sample #(
  parameter int unsigned N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_i,
  output logic [N_SRC-1:0] src_d_o,
  output logic [N_SRC-1:0] src_q_o
);

  logic [N_SRC-1:0] src_d;
  logic [N_SRC-1:0] src_q;
  logic             past_ok_q;

  // Level follower: the next state is the present line level.
  always_comb begin
    src_d = req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q     <= '0;
      past_ok_q <= 1'b0;
    end else begin
      src_q     <= src_d;
      past_ok_q <= 1'b1;
    end
  end

  assign src_d_o = src_d;
  assign src_q_o = src_q;

  // R1: the source register mirrors the line levels seen one edge earlier
  p_src_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> (src_q == $past(req_i)));

endmodule

// File: rtl/maskirq_mask_reg.sv
module maskirq_mask_reg #(
  parameter int unsigned        N_SRC    = 16,
  parameter int unsigned        DATA_W   = 16,
  parameter logic [N_SRC-1:0]   MASK_RST = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N_SRC-1:0]  mask_d_o,
  output logic [N_SRC-1:0]  mask_q_o
);

  logic [N_SRC-1:0] mask_d;
  logic [N_SRC-1:0] mask_q;

  always_comb begin
    mask_d = mask_q;
    if (load_i) begin
      mask_d = wdata_i[N_SRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
    end else if (load_i) begin
      mask_q <= mask_d;
    end
  end

  assign mask_d_o = mask_d;
  assign mask_q_o = mask_q;

  // R4: a decoded mask write lands in the register at that edge
  p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (mask_q == $past(wdata_i[N_SRC-1:0])));

  // R7: without a decoded mask write the mask keeps its value
  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(mask_q));

endmodule

// File: rtl/maskirq_lowest_enc.sv
module maskirq_lowest_enc #(
  parameter int unsigned N_SRC     = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned VEC_SHIFT = 2
) (
  input  logic [N_SRC-1:0]  pend_i,
  output logic [DATA_W-1:0] code_o
);

  // below[i] is set when any lower-numbered bit is pending.
  logic [N_SRC-1:0] below;
  logic [N_SRC-1:0] hit;

  assign below[0] = 1'b0;

  genvar g;
  generate
    for (g = 1; g < N_SRC; g++) begin : g_chain
      assign below[g] = below[g-1] | pend_i[g-1];
    end
  endgenerate

  // At most one bit of hit is set: the lowest pending source.
  assign hit = pend_i & ~below;

  always_comb begin
    code_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (hit[i]) begin
        code_o = code_o | DATA_W'((i + 1) << VEC_SHIFT);
      end
    end
  end

endmodule

// File: rtl/maskirq_port.sv
module maskirq_port
  import maskirq_pkg::*;
#(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] vec_code_i,
  input  logic [N_SRC-1:0]  mask_q_i,
  output logic              mask_load_o,
  output logic [DATA_W-1:0] rdata_o
);

  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    if (addr_i == ADDR_W'(OFF_VECTOR)) begin
      sel = SEL_VEC;
    end else if (addr_i == ADDR_W'(OFF_MASK)) begin
      sel = SEL_MASK;
    end else begin
      sel = SEL_NONE;
    end
  end

  // Only the mask offset accepts writes; the vector offset is read-only.
  assign mask_load_o = wr_i && (sel == SEL_MASK);

  always_comb begin
    unique case (sel)
      SEL_VEC:  rd_mux = vec_code_i;
      SEL_MASK: rd_mux = DATA_W'(mask_q_i);
      default:  rd_mux = '0;
    endcase
  end

  always_comb begin
    rdata_d = rd_i ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

  // R9: no read strobe, no read data in the next cycle
  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> (rdata_o == '0));

  // R6: undefined offsets read back as zero
  p_undef_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && (sel == SEL_NONE)) |=> (rdata_o == '0));

  // R4, R9: a mask read returns the mask as held before that edge
  p_mask_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && (sel == SEL_MASK)) |=> (rdata_o == DATA_W'($past(mask_q_i))));

endmodule

// File: rtl/maskirq_ctrl.sv
module maskirq_ctrl
  import maskirq_pkg::*;
#(
  parameter int unsigned      N_SRC     = 16,
  parameter int unsigned      DATA_W    = 16,
  parameter int unsigned      ADDR_W    = 12,
  parameter int unsigned      VEC_SHIFT = 2,
  parameter logic [N_SRC-1:0] MASK_RST  = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_req_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_rd_i,
  input  logic              acc_wr_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic [DATA_W-1:0] acc_rdata_o,
  output logic              irq_o
);

  logic [N_SRC-1:0]  src_d;
  logic [N_SRC-1:0]  src_q;
  logic [N_SRC-1:0]  mask_d;
  logic [N_SRC-1:0]  mask_q;
  logic [N_SRC-1:0]  pend;
  logic [DATA_W-1:0] vec_code;
  logic              mask_load;
  logic              irq_d;
  logic              irq_q;

  maskirq_src_sample #(.N_SRC(N_SRC)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (irq_req_i),
    .src_d_o (src_d),
    .src_q_o (src_q)
  );

  maskirq_mask_reg #(
    .N_SRC    (N_SRC),
    .DATA_W   (DATA_W),
    .MASK_RST (MASK_RST)
  ) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (mask_load),
    .wdata_i  (acc_wdata_i),
    .mask_d_o (mask_d),
    .mask_q_o (mask_q)
  );

  assign pend = src_q & mask_q;

  maskirq_lowest_enc #(
    .N_SRC     (N_SRC),
    .DATA_W    (DATA_W),
    .VEC_SHIFT (VEC_SHIFT)
  ) u_enc (
    .pend_i (pend),
    .code_o (vec_code)
  );

  maskirq_port #(
    .N_SRC  (N_SRC),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_i      (acc_addr_i),
    .rd_i        (acc_rd_i),
    .wr_i        (acc_wr_i),
    .vec_code_i  (vec_code),
    .mask_q_i    (mask_q),
    .mask_load_o (mask_load),
    .rdata_o     (acc_rdata_o)
  );

  // The output flop is fed from next-state values, so it lines up with the
  // source and mask registers and carries no combinational glitches.
  always_comb begin
    irq_d = |(src_d & mask_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // R2: the output agrees with the held source and mask every cycle
  p_irq_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|(src_q & mask_q)));

  // R3: the vector code is zero exactly when nothing enabled is pending
  p_vec_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_code == '0) == (pend == '0));

endmodule

// File: tb/maskirq_ctrl_test.sv
`timescale 1ns/1ps
module maskirq_ctrl_test;

  logic        clk;
  logic        rst_n;
  logic [15:0] irq_req;
  logic [11:0] addr;
  logic        rd;
  logic        wr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  string cur_req = "R5";

  // Reference model state (value expected after the pending edge)
  logic [15:0] m_src;
  logic [15:0] m_mask;
  logic [15:0] exp_rdata;
  logic        exp_irq;

  maskirq_ctrl uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req_i   (irq_req),
    .acc_addr_i  (addr),
    .acc_rd_i    (rd),
    .acc_wr_i    (wr),
    .acc_wdata_i (wdata),
    .acc_rdata_o (rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] model_vec(input logic [15:0] p);
    for (int i = 0; i < 16; i++) begin
      if (p[i]) return 16'((i + 1) * 4);
    end
    return 16'h0000;
  endfunction

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%04h expected 0x%04h", cur_req, what, act, exp);
    end
  endtask

  // One cycle: compare outputs at the falling edge, then drive and predict.
  task automatic step(input logic [15:0] lines, input logic r, input logic w,
                      input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    chk("irq_o", {15'd0, irq}, {15'd0, exp_irq});
    chk("rdata", rdata, exp_rdata);
    if (r) begin
      if (a == 12'h000)      exp_rdata = model_vec(m_src & m_mask);
      else if (a == 12'h002) exp_rdata = m_mask;
      else                   exp_rdata = 16'h0000;
    end else begin
      exp_rdata = 16'h0000;
    end
    if (w && a == 12'h002) m_mask = d;
    m_src   = lines;
    exp_irq = |(m_src & m_mask);
    irq_req = lines;
    rd      = r;
    wr      = w;
    addr    = a;
    wdata   = d;
  endtask

  initial begin
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; addr = '0; rd = 0; wr = 0; wdata = '0;
    m_src = '0; m_mask = 16'h0010; exp_rdata = '0; exp_irq = 0;

    // R5: outputs quiet while reset is held
    cur_req = "R5";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("irq_o in reset", {15'd0, irq}, 16'h0000);
      chk("rdata in reset", rdata, 16'h0000);
    end
    rst_n = 1'b1;
    step(16'h0000, 1, 0, 12'h002, 0);        // mask default 0x0010
    step(16'h0000, 1, 0, 12'h000, 0);        // vector 0
    step(16'h0010, 0, 0, 12'h000, 0);        // source 4 enabled by default
    step(16'h0010, 1, 0, 12'h000, 0);        // vector 0x0014

    // R1 / R3: levels followed, lowest index encoded
    cur_req = "R3";
    step(16'h0000, 0, 1, 12'h002, 16'hFFFF);
    step(16'h0001, 1, 0, 12'h000, 0);
    step(16'h8000, 1, 0, 12'h000, 0);
    step(16'h0300, 1, 0, 12'h000, 0);
    step(16'h8420, 1, 0, 12'h000, 0);
    step(16'hFFFF, 1, 0, 12'h000, 0);
    step(16'h0000, 1, 0, 12'h000, 0);
    cur_req = "R1";
    step(16'h0200, 1, 0, 12'h000, 0);        // one-cycle pulse
    step(16'h0000, 1, 0, 12'h000, 0);
    step(16'h0000, 1, 0, 12'h000, 0);        // no latched request left
    step(16'h0000, 0, 0, 12'h000, 0);

    // R2: output is source AND mask
    cur_req = "R2";
    step(16'h0F0F, 0, 1, 12'h002, 16'h00F0);
    step(16'h0F0F, 0, 0, 12'h000, 0);
    step(16'h0010, 0, 0, 12'h000, 0);
    step(16'h0010, 0, 1, 12'h002, 16'h0000);
    step(16'h0010, 0, 1, 12'h002, 16'h0010);
    step(16'h0000, 0, 0, 12'h000, 0);

    // R4: mask write and read back
    cur_req = "R4";
    step(16'h0000, 0, 1, 12'h002, 16'hA5C3);
    step(16'h0000, 1, 0, 12'h002, 0);
    step(16'h0000, 0, 1, 12'h002, 16'h0000);
    step(16'h0000, 1, 0, 12'h002, 0);

    // R7: writes elsewhere are ignored
    cur_req = "R7";
    step(16'h0004, 0, 1, 12'h002, 16'h1234);
    step(16'h0004, 0, 1, 12'h000, 16'hFFFF);
    step(16'h0004, 0, 1, 12'h004, 16'hFFFF);
    step(16'h0004, 0, 1, 12'h003, 16'hFFFF);
    step(16'h0004, 0, 1, 12'hFFE, 16'hFFFF);
    step(16'h0004, 1, 0, 12'h002, 0);

    // R6: undefined reads return zero
    cur_req = "R6";
    step(16'hFFFF, 0, 1, 12'h002, 16'hFFFF);
    step(16'hFFFF, 1, 0, 12'h001, 0);
    step(16'hFFFF, 1, 0, 12'h003, 0);
    step(16'hFFFF, 1, 0, 12'h004, 0);
    step(16'hFFFF, 1, 0, 12'h800, 0);
    step(16'hFFFF, 1, 0, 12'hFFE, 0);

    // R8: vector reads have no side effect
    cur_req = "R8";
    step(16'h0040, 0, 0, 12'h000, 0);
    for (int i = 0; i < 4; i++) step(16'h0040, 1, 0, 12'h000, 0);
    step(16'h0040, 1, 0, 12'h002, 0);

    // R9: collisions in one cycle
    cur_req = "R9";
    step(16'h0001, 1, 1, 12'h002, 16'h0002);  // read returns old mask
    step(16'h0002, 1, 1, 12'h002, 16'h0001);  // lines and mask swap together
    step(16'h0003, 0, 1, 12'h002, 16'h0000);
    step(16'h0000, 0, 0, 12'h000, 0);

    // Mixed stimulus, all requirements through the model
    cur_req = "R2";
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      case ($urandom_range(0, 3))
        0: a = 12'h000;
        1: a = 12'h002;
        2: a = 12'h004;
        default: a = 12'h001;
      endcase
      step(16'($urandom) & 16'($urandom), 1'($urandom), 1'($urandom), a, 16'($urandom));
    end
    step(16'h0000, 0, 0, 12'h000, 0);
    step(16'h0000, 0, 0, 12'h000, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule